// File: doc/BRIEF.md
# Aliased Shifting Key Store with Reload Buffer

This block holds the 256-bit key of a block-cipher peripheral as eight 32-bit words. Words 3..0 form the low group and words 7..4 the high group. Each group is a four-word shift register. The bus reaches each group through four consecutive word addresses that all decode to the same group. A DMA channel that increments its address can therefore stream all eight key words in one burst: the first four writes land in the low group and the next four land in the high group.

The cipher engine overwrites the working key while it runs. In 128-bit mode the high group can act as a spare copy of the key. When the buffer is enabled, starting an operation copies words 7..4 into words 3..0. The engine sees the copied key in the cycle of the start pulse, so software does not rewrite the key before each block. An engine write-back port stores the transformed key: only the low half in 128-bit mode, and the whole key in 256-bit mode.

Each group picks one action per cycle: HOLD, LOAD, SHIFT_IN or ROTATE. The choice is made by a fixed priority: a load from the engine or the reload path comes first, then a bus write, then a bus read. The group's register takes the chosen action at the clock edge.

Top module: `aliased_key_store`

## Requirements
- R1: After reset all 256 bits of `key_o` are zero.
- R2: A bus write whose address bit 4 is 0 shifts the low group toward word 0: word i takes word i+1, and word 3 takes `bus_wdata`. Word 0 is `key_o[31:0]`.
- R3: A bus write whose address bit 4 is 1 shifts the high group in the same way, with `bus_wdata` entering word 7 (`key_o[255:224]`).
- R4: Eight writes at byte addresses 0x00, 0x04, ..., 0x1C leave the n-th written word (counting from 0) in key word n.
- R5: A bus read (`bus_rd`=1, `bus_wr`=0) returns word 0 of the addressed group in the same cycle, or word 4 for the high group. It then rotates that group: word 3 takes the old word 0 (word 7 takes the old word 4 for the high group), so four reads restore the group.
- R6: Every address bit except bit 4 is ignored. All 32 byte addresses reach one of the two groups.
- R7: With `mode_256`=0 and `buf_en`=1, an `op_start` pulse puts words 7..4 on `key_o[127:0]` in the same cycle and copies them into words 3..0 at the clock edge.
- R8: With `mode_256`=1, `op_start` leaves the key unchanged whatever the value of `buf_en`.
- R9: With `buf_en`=0, `op_start` leaves the key unchanged.
- R10: `eng_we` loads `eng_key[127:0]` into words 3..0. In 256-bit mode it also loads `eng_key[255:128]` into words 7..4.
- R11: Within one group, the priorities are engine write first, then reload, then bus write, then bus read. A reload uses the high words as they stood before the edge.
- R12: A bus access to one group leaves the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a write takes precedence) |
| bus_addr | input | 5 | Byte address; only bit 4 selects the group |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Least significant word of the addressed group |
| mode_256 | input | 1 | 1 selects 256-bit keys, 0 selects 128-bit |
| buf_en | input | 1 | Enables reload of the low group from the high group |
| op_start | input | 1 | Start-of-operation pulse |
| eng_we | input | 1 | Engine write-back strobe |
| eng_key | input | 256 | Key value written back by the engine |
| key_o | output | 256 | Working key presented to the engine |

## Verification
The hardest situations to reach are the single-cycle collisions. These are an engine write-back, a reload start and a bus shift that all target the low group on the same edge, and a reload that coincides with a high-group write and so must copy the high words as they were before the shift. The bench drives these ports together within one low clock phase and predicts the outcome from the priority order. The same-cycle bypass on `key_o` exists only while `op_start` is high, so the bench samples it between the driving negedge and the next rising edge.

// File: rtl/aks_pkg.sv
package aks_pkg;

    typedef enum logic [1:0] {
        GRP_HOLD     = 2'd0,
        GRP_LOAD     = 2'd1,
        GRP_SHIFT_IN = 2'd2,
        GRP_ROTATE   = 2'd3
    } grp_act_t;

    // Priority: whole-group load, then bus write, then bus read
    function automatic grp_act_t pick_act(input logic load, input logic wr, input logic rd);
        if (load)    return GRP_LOAD;
        else if (wr) return GRP_SHIFT_IN;
        else if (rd) return GRP_ROTATE;
        else         return GRP_HOLD;
    endfunction

endpackage

// File: rtl/aks_bus_decode.sv
module aks_bus_decode (
    input  logic bus_sel,
    input  logic bus_wr,
    input  logic bus_rd,
    input  logic grp_bit,
    output logic wr_lo,
    output logic rd_lo,
    output logic wr_hi,
    output logic rd_hi
);
    logic wr_any;
    logic rd_any;

    always_comb begin
        wr_any = bus_sel && bus_wr;
        rd_any = bus_sel && bus_rd && !bus_wr;
        wr_lo  = wr_any && !grp_bit;
        rd_lo  = rd_any && !grp_bit;
        wr_hi  = wr_any &&  grp_bit;
        rd_hi  = rd_any &&  grp_bit;
    end
endmodule

// File: rtl/aks_word_group.sv
module aks_word_group
    import aks_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  grp_act_t                  act,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [WORDS*WORD_W-1:0]   load_data,
    output logic [WORDS*WORD_W-1:0]   words_o,
    output logic [WORD_W-1:0]         lsw_o
);
    logic [WORDS-1:0][WORD_W-1:0] q;
    logic [WORDS-1:0][WORD_W-1:0] nxt;

    always_comb begin
        nxt = q;
        unique case (act)
            GRP_HOLD: ;
            GRP_LOAD: nxt = load_data;
            GRP_SHIFT_IN: begin
                for (int i = 0; i < WORDS-1; i++) nxt[i] = q[i+1];
                nxt[WORDS-1] = wdata;
            end
            GRP_ROTATE: begin
                for (int i = 0; i < WORDS-1; i++) nxt[i] = q[i+1];
                nxt[WORDS-1] = q[0];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign words_o = q;
    assign lsw_o   = q[0];

    // R2 / R3: a write shifts toward word 0 and enters at the top
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == GRP_SHIFT_IN) |=> (q[WORDS-1] == $past(wdata)) && (q[0] == $past(q[1])));

    // R5: a read rotates the old bottom word to the top
    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act == GRP_ROTATE) |=> (q[WORDS-1] == $past(q[0])) && (q[0] == $past(q[1])));

    // R11: a hold cycle keeps the group
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act == GRP_HOLD) |=> $stable(q));
endmodule

// File: rtl/aliased_key_store.sv
module aliased_key_store
    import aks_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int GRP_WORDS = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    input  logic                          mode_256,
    input  logic                          buf_en,
    input  logic                          op_start,
    input  logic                          eng_we,
    input  logic [2*GRP_WORDS*WORD_W-1:0] eng_key,
    output logic [2*GRP_WORDS*WORD_W-1:0] key_o
);
    localparam int HALF_W  = GRP_WORDS * WORD_W;
    localparam int KEY_W   = 2 * HALF_W;
    localparam int GRP_BIT = $clog2(GRP_WORDS * WORD_W / 8);

    logic              wr_lo, rd_lo, wr_hi, rd_hi;
    logic              reload_now;
    logic              lo_load, hi_load;
    logic [HALF_W-1:0] lo_words, hi_words;
    logic [HALF_W-1:0] lo_load_data;
    logic [WORD_W-1:0] lo_lsw, hi_lsw;
    grp_act_t          lo_act, hi_act;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^bus_addr;

    aks_bus_decode u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .grp_bit (bus_addr[GRP_BIT]),
        .wr_lo   (wr_lo),
        .rd_lo   (rd_lo),
        .wr_hi   (wr_hi),
        .rd_hi   (rd_hi)
    );

    always_comb begin
        reload_now   = op_start && buf_en && !mode_256;
        lo_load      = eng_we || reload_now;
        hi_load      = eng_we && mode_256;
        lo_load_data = eng_we ? eng_key[HALF_W-1:0] : hi_words;
        lo_act       = pick_act(lo_load, wr_lo, rd_lo);
        hi_act       = pick_act(hi_load, wr_hi, rd_hi);
    end

    aks_word_group #(.WORDS(GRP_WORDS), .WORD_W(WORD_W)) u_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (lo_act),
        .wdata     (bus_wdata),
        .load_data (lo_load_data),
        .words_o   (lo_words),
        .lsw_o     (lo_lsw)
    );

    aks_word_group #(.WORDS(GRP_WORDS), .WORD_W(WORD_W)) u_hi (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (hi_act),
        .wdata     (bus_wdata),
        .load_data (eng_key[KEY_W-1:HALF_W]),
        .words_o   (hi_words),
        .lsw_o     (hi_lsw)
    );

    // Reload bypass lets the engine see the buffered key in the start cycle
    assign key_o     = {hi_words, (reload_now ? hi_words : lo_words)};
    assign bus_rdata = bus_addr[GRP_BIT] ? hi_lsw : lo_lsw;

    // R7: a buffered start copies the high words into the low words
    p_reload_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && buf_en && !mode_256 && !eng_we) |=> (lo_words == $past(hi_words)));

    // R8: in 256-bit mode a start changes nothing
    p_wide_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && mode_256 && !eng_we && !bus_sel) |=> ($stable(lo_words) && $stable(hi_words)));

    // R10: engine write-back reaches the low words
    p_engine_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> (lo_words == $past(eng_key[HALF_W-1:0])));

    // R12: a low-group access leaves the high group alone
    p_hi_isolated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_addr[GRP_BIT] && !(eng_we && mode_256)) |=> $stable(hi_words));
endmodule

// File: tb/test_aliased_key_store.sv
module test_aliased_key_store;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         mode_256 = 1'b0, buf_en = 1'b0, op_start = 1'b0, eng_we = 1'b0;
    logic [255:0] eng_key = '0;
    logic [255:0] key_o;

    logic [3:0][31:0] m_lo = '0;
    logic [3:0][31:0] m_hi = '0;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    aliased_key_store i_aliased_key_store (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_256(mode_256), .buf_en(buf_en), .op_start(op_start), .eng_we(eng_we),
        .eng_key(eng_key), .key_o(key_o)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; model follows the requirement priorities (R11)
    task automatic step(input string req, input logic sel, input logic wr, input logic rd,
                        input logic [4:0] a, input logic [31:0] d, input logic st,
                        input logic we, input logic [255:0] ek);
        logic [3:0][31:0] n_lo, n_hi;
        logic reload;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        op_start = st; eng_we = we; eng_key = ek;
        reload = st && buf_en && !mode_256;
        #1;
        check({req, " same-cycle key"}, key_o, {m_hi, (reload ? m_hi : m_lo)});
        if (sel && rd && !wr)
            check({req, " R5 rdata"}, {224'd0, bus_rdata}, {224'd0, (a[4] ? m_hi[0] : m_lo[0])});
        n_lo = m_lo; n_hi = m_hi;
        if (we)                       n_lo = ek[127:0];
        else if (reload)              n_lo = m_hi;
        else if (sel && wr && !a[4])  n_lo = {d, m_lo[3:1]};
        else if (sel && rd && !a[4])  n_lo = {m_lo[0], m_lo[3:1]};
        if (we && mode_256)           n_hi = ek[255:128];
        else if (sel && wr && a[4])   n_hi = {d, m_hi[3:1]};
        else if (sel && rd && a[4])   n_hi = {m_hi[0], m_hi[3:1]};
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0; bus_rd = 0; op_start = 0; eng_we = 0;
        m_lo = n_lo; m_hi = n_hi;
        #1;
        check({req, " after edge"}, key_o, {m_hi, m_lo});
    endtask

    function automatic logic [255:0] epat(input logic [31:0] seed);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = seed ^ (32'h0101_0101 * (k + 1));
        return r;
    endfunction

    task automatic load8(input logic [31:0] base);
        for (int i = 0; i < 8; i++)
            step("R4 burst", 1, 1, 0, 5'(i*4), base + 32'(i), 0, 0, '0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [255:0] exp;
        #20;
        check("R1 reset", key_o, '0);
        rst_n = 1;
        #10;
        check("R1 after release", key_o, '0);

        // R4: incrementing burst places word n at key word n
        load8(32'hA000_0000);
        for (int i = 0; i < 8; i++) exp[i*32 +: 32] = 32'hA000_0000 + 32'(i);
        check("R4 full key", key_o, exp);

        // R2 R3 R6 R12: every byte address, one write each
        for (int a = 0; a < 32; a++)
            step(a < 16 ? "R2 R6 R12 low alias" : "R3 R6 R12 high alias",
                 1, 1, 0, 5'(a), 32'hC000_0000 | 32'(a * 7), 0, 0, '0);

        // R5: four reads per group via different aliases restore the group
        exp = key_o;
        for (int i = 0; i < 4; i++) step("R5 low read", 1, 0, 1, 5'(i*4 + 1), '0, 0, 0, '0);
        for (int i = 0; i < 4; i++) step("R5 high read", 1, 0, 1, 5'(16 + i*4 + 2), '0, 0, 0, '0);
        check("R5 restored", key_o, exp);
        step("R5 write wins over read", 1, 1, 1, 5'h04, 32'h1234_5678, 0, 0, '0);

        // R7 R8 R9 R10: sweep mode and buffer enable
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
                mode_256 = m[0]; buf_en = b[0];
                load8(32'h5000_0000 + 32'(m * 64 + b * 16));
                step(m ? "R8 wide start" : (b ? "R7 reload" : "R9 no buffer"),
                     0, 0, 0, '0, '0, 1, 0, '0);
                step("R10 engine write", 0, 0, 0, '0, '0, 0, 1, epat(32'(m * 4 + b)));
                step(m ? "R8 start after engine" : (b ? "R7 reload after engine" : "R9 start after engine"),
                     0, 0, 0, '0, '0, 1, 0, '0);
            end
        end

        // R11: collisions in one cycle
        mode_256 = 0; buf_en = 1;
        load8(32'h7700_0000);
        step("R11 engine over reload and write", 1, 1, 0, 5'h08, 32'hDEAD_0001, 1, 1, epat(32'h99));
        load8(32'h8800_0000);
        step("R11 reload over low write", 1, 1, 0, 5'h00, 32'hDEAD_0002, 1, 0, '0);
        load8(32'h9900_0000);
        step("R11 reload uses pre-edge high", 1, 1, 0, 5'h10, 32'hDEAD_0003, 1, 0, '0);
        mode_256 = 1;
        step("R11 R10 wide engine over high write", 1, 1, 0, 5'h14, 32'hDEAD_0004, 0, 1, epat(32'h5A));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule